// File: doc/BRIEF.md
# Configurable Radix-8/4/2 Butterfly

This block is the butterfly engine of a memory-based transform processor. Each operation takes eight complex samples. The datapath is three cascaded radix-2 layers. A per-operation mode configures it as one 8-point butterfly, as two independent 4-point butterflies (lanes 0-3 and 4-7), or as four independent 2-point butterflies (lane pairs 0/1, 2/3, 4/5, 6/7). Every stage of a transform except the last runs in 8-point mode. The last stage picks its mode from the transform length:

- 8-point for 512 points.
- 4-point for 256 and 2048 points.
- 2-point for 128 and 1024 points.

Inside the 8-point form the layers apply fixed rotations. These are -j and the first and third eighth roots of unity. The eighth-root rotations use a 12-bit fractional constant and round to nearest. No general twiddle multiply is done here.

An inverse flag, sampled with each operation, conjugates the samples on the way in and on the way out. This turns the forward hardware into an inverse transform without scaling. Results carry 3 guard bits and leave unscaled for the downstream scaling stage.

Operations enter on a valid/ready stream. They leave one cycle later from a single output register that also holds a valid/ready stream. The upstream may change `in_data`, `in_mode` and `in_inv` only when a beat is accepted (`in_valid` and `in_ready` both high at a clock edge). A result held with `out_ready` low stays unchanged until it is taken. The block accepts a new operation in the same cycle the held result is read, so it sustains one operation per clock.

Top module: `cbf_butterfly`

## Requirements
- R1: While `rst` is high and after its release until the first accepted operation, `out_valid` is 0; `in_ready` is 1 after reset.
- R2: `in_ready` is 1 exactly when the output register is empty or being read (`out_ready`=1). An operation accepted at edge t appears on `out_data` with `out_valid`=1 after edge t. `out_valid` falls after a read with no new acceptance.
- R3: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold and `in_ready` is 0.
- R4: Mode 0 (2-point): y[2i]=x[2i]+x[2i+1] and y[2i+1]=x[2i]-x[2i+1] for i=0..3, exact.
- R5: Mode 1 (4-point): lanes 4g..4g+3 give the exact 4-point forward DFT of the same lanes, in natural order (g=0,1).
- R6: Mode 2, and the unused code 3, give the 8-point forward DFT of all lanes in natural order. Each component is within 3 of the exact value, and it is exact when only lane 0 is nonzero.
- R7: An odd eighth-root rotation of (a,b) forms (a+b, b-a) for the first root or (b-a, -(a+b)) for the third. Each component s is then scaled as (s*2896+2048)>>>12. So lane 1=(1000,0) alone in mode 2 gives y1=(707,-707), y3=(-707,-707), y5=(-707,707), y7=(707,707).
- R8: With `in_inv`=1, the result is conj(F(conj(x))) for the selected mode F, i.e. the unscaled inverse DFT.
- R9: Mode and inverse flag are taken per operation, so back-to-back operations in different modes each follow their own setting.
- R10: Lane n real part is at `in_data[24n +: 12]` and imaginary part at `in_data[24n+12 +: 12]`. Outputs use the same order with 15-bit fields (`out_data[30n +: 15]`, `[30n+15 +: 15]`), two's complement. Eight full-scale equal lanes (2047,-2048) give y0=(16376,-16384) and zeros elsewhere without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_mode | input | 2 | 0: four 2-point, 1: two 4-point, 2/3: one 8-point |
| in_inv | input | 1 | 1 selects inverse (conjugate in and out) |
| in_data | input | 192 | Eight complex 12-bit samples |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 240 | Eight complex 15-bit results |

## Verification
Two things can fall in the same cycle: the downstream reading a held result, and the upstream handing over the next operation. The bench provokes this by presenting a 2-point operation and then an 8-point operation on consecutive clocks with `out_ready` high. It checks that each result matches its own mode. It also stalls the output with a second operation waiting, then releases it. The release must retire the first result and admit the second on the same edge, with the held data unchanged before that.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam int BF_LANES  = 8;
  localparam int ROT_FRAC  = 12;
  localparam int ROT_K     = 2896;

  typedef enum logic [1:0] {
    BF_R2  = 2'd0,
    BF_R4  = 2'd1,
    BF_R8  = 2'd2,
    BF_R8X = 2'd3
  } bf_mode_e;

  function automatic int br3(input int k);
    return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
  endfunction

  function automatic int br2(input int k);
    return ((k & 1) << 1) | ((k >> 1) & 1);
  endfunction
endpackage

// File: rtl/cbf_rot8.sv
module cbf_rot8 import cbf_pkg::*; #(
  parameter int IW    = 15,
  parameter bit THIRD = 1'b0
) (
  input  logic signed [IW-1:0] re_i,
  input  logic signed [IW-1:0] im_i,
  output logic signed [IW-1:0] re_o,
  output logic signed [IW-1:0] im_o
);
  localparam int PW    = IW + 15;
  localparam int ROUND = 1 << (ROT_FRAC - 1);

  logic signed [IW:0]   sum, dif, s_re, s_im;
  logic signed [PW-1:0] p_re, p_im, q_re, q_im;

  assign sum = {re_i[IW-1], re_i} + {im_i[IW-1], im_i};
  assign dif = {im_i[IW-1], im_i} - {re_i[IW-1], re_i};

  generate
    if (THIRD) begin : g_third
      assign s_re = dif;
      assign s_im = -sum;
    end else begin : g_first
      assign s_re = sum;
      assign s_im = dif;
    end
  endgenerate

  assign p_re = {{(PW-IW-1){s_re[IW]}}, s_re} * PW'(ROT_K) + PW'(ROUND);
  assign p_im = {{(PW-IW-1){s_im[IW]}}, s_im} * PW'(ROT_K) + PW'(ROUND);
  assign q_re = p_re >>> ROT_FRAC;
  assign q_im = p_im >>> ROT_FRAC;
  assign re_o = q_re[IW-1:0];
  assign im_o = q_im[IW-1:0];
endmodule

// File: rtl/cbf_layer.sv
module cbf_layer import cbf_pkg::*; #(
  parameter int IW   = 15,
  parameter int SPAN = 4
) (
  input  logic                 en,
  input  logic signed [IW-1:0] re_i [BF_LANES],
  input  logic signed [IW-1:0] im_i [BF_LANES],
  output logic signed [IW-1:0] re_o [BF_LANES],
  output logic signed [IW-1:0] im_o [BF_LANES]
);
  localparam int PAIRS = BF_LANES / 2;
  localparam int STEP  = 4 / SPAN;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int GRP = p / SPAN;
      localparam int POS = p % SPAN;
      localparam int TOP = GRP * 2 * SPAN + POS;
      localparam int BOT = TOP + SPAN;
      localparam int EXP = POS * STEP;

      logic signed [IW-1:0] a_re, a_im, d_re, d_im, r_re, r_im;

      assign a_re = re_i[TOP] + re_i[BOT];
      assign a_im = im_i[TOP] + im_i[BOT];
      assign d_re = re_i[TOP] - re_i[BOT];
      assign d_im = im_i[TOP] - im_i[BOT];

      if (EXP == 0) begin : g_w0
        assign r_re = d_re;
        assign r_im = d_im;
      end else if (EXP == 2) begin : g_wmj
        assign r_re = d_im;
        assign r_im = -d_re;
      end else begin : g_wodd
        cbf_rot8 #(.IW(IW), .THIRD(EXP == 3)) u_rot (
          .re_i(d_re), .im_i(d_im), .re_o(r_re), .im_o(r_im)
        );
      end

      assign re_o[TOP] = en ? a_re : re_i[TOP];
      assign im_o[TOP] = en ? a_im : im_i[TOP];
      assign re_o[BOT] = en ? r_re : re_i[BOT];
      assign im_o[BOT] = en ? r_im : im_i[BOT];
    end
  endgenerate
endmodule

// File: rtl/cbf_butterfly.sv
module cbf_butterfly import cbf_pkg::*; #(
  parameter int W     = 12,
  parameter int GUARD = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [1:0]                          in_mode,
  input  logic                                in_inv,
  input  logic [BF_LANES*2*W-1:0]             in_data,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [BF_LANES*2*(W+GUARD)-1:0]     out_data
);
  localparam int OW = W + GUARD;

  logic signed [OW-1:0] x_re [BF_LANES];
  logic signed [OW-1:0] x_im [BF_LANES];
  logic signed [OW-1:0] s1_re [BF_LANES];
  logic signed [OW-1:0] s1_im [BF_LANES];
  logic signed [OW-1:0] s2_re [BF_LANES];
  logic signed [OW-1:0] s2_im [BF_LANES];
  logic signed [OW-1:0] c_re [BF_LANES];
  logic signed [OW-1:0] c_im [BF_LANES];
  logic [BF_LANES*2*OW-1:0] nxt;
  logic mode_r8, mode_r4, take;

  assign mode_r8  = in_mode[1];
  assign mode_r4  = (in_mode == BF_R4);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  generate
    for (genvar n = 0; n < BF_LANES; n++) begin : g_in
      logic signed [OW-1:0] e_im;
      assign x_re[n] = {{GUARD{in_data[n*2*W+W-1]}}, in_data[n*2*W +: W]};
      assign e_im    = {{GUARD{in_data[n*2*W+2*W-1]}}, in_data[n*2*W+W +: W]};
      assign x_im[n] = in_inv ? -e_im : e_im;
    end
  endgenerate

  cbf_layer #(.IW(OW), .SPAN(4)) u_l1 (
    .en(mode_r8), .re_i(x_re), .im_i(x_im), .re_o(s1_re), .im_o(s1_im)
  );
  cbf_layer #(.IW(OW), .SPAN(2)) u_l2 (
    .en(mode_r8 || mode_r4), .re_i(s1_re), .im_i(s1_im), .re_o(s2_re), .im_o(s2_im)
  );
  cbf_layer #(.IW(OW), .SPAN(1)) u_l3 (
    .en(1'b1), .re_i(s2_re), .im_i(s2_im), .re_o(c_re), .im_o(c_im)
  );

  // Natural-order output: undo the bit reversal of the selected butterfly size.
  generate
    for (genvar k = 0; k < BF_LANES; k++) begin : g_out
      localparam int I8 = br3(k);
      localparam int I4 = (k & 4) | br2(k & 3);
      logic signed [OW-1:0] y_re, y_im;
      assign y_re = mode_r8 ? c_re[I8] : (mode_r4 ? c_re[I4] : c_re[k]);
      assign y_im = mode_r8 ? c_im[I8] : (mode_r4 ? c_im[I4] : c_im[k]);
      assign nxt[k*2*OW +: OW]    = y_re;
      assign nxt[k*2*OW+OW +: OW] = in_inv ? -y_im : y_im;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (take) begin
      out_data <= nxt;
    end
  end
endmodule

// File: rtl/cbf_butterfly_chk.sv
module cbf_butterfly_chk import cbf_pkg::*; #(
  parameter int W     = 12,
  parameter int GUARD = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            in_valid,
  input logic                            in_ready,
  input logic [1:0]                      in_mode,
  input logic                            in_inv,
  input logic [BF_LANES*2*W-1:0]         in_data,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [BF_LANES*2*(W+GUARD)-1:0] out_data
);
  localparam int OW = W + GUARD;

  logic signed [OW-1:0] pair0_sum;
  assign pair0_sum = OW'($signed(in_data[0 +: W])) + OW'($signed(in_data[2*W +: W]));

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R2
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid && (out_ready || !out_valid) |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3
  block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R4
  pair_sum_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_mode == BF_R2 && !in_inv
    |=> out_data[0 +: OW] == $past(pair0_sum));
endmodule

bind cbf_butterfly cbf_butterfly_chk #(.W(W), .GUARD(GUARD)) u_chk (.*);

// File: tb/tb_cbf_butterfly.sv
module tb_cbf_butterfly;
  localparam int W  = 12;
  localparam int OW = 15;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_mode = 2'd0;
  logic in_inv = 1'b0;
  logic [8*2*W-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [8*2*OW-1:0] out_data;

  int xr [8];
  int xi [8];
  real er [8];
  real ei [8];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  cbf_butterfly dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_inv(in_inv), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #10 clk = ~clk;

  function automatic logic [8*2*W-1:0] pack_in();
    logic [8*2*W-1:0] d;
    for (int n = 0; n < 8; n++) begin
      d[n*2*W +: W]   = xr[n][W-1:0];
      d[n*2*W+W +: W] = xi[n][W-1:0];
    end
    return d;
  endfunction

  function automatic int out_re(input int k);
    return int'($signed(out_data[k*2*OW +: OW]));
  endfunction

  function automatic int out_im(input int k);
    return int'($signed(out_data[k*2*OW+OW +: OW]));
  endfunction

  task automatic load_pat(input int sel);
    for (int n = 0; n < 8; n++) begin
      xr[n] = ((sel * 37 + n * 53) % 401) - 200;
      xi[n] = ((sel * 71 + n * 29) % 301) - 150;
    end
  endtask

  task automatic clear_pat();
    for (int n = 0; n < 8; n++) begin
      xr[n] = 0;
      xi[n] = 0;
    end
  endtask

  // Reference DFT per group of the selected size.
  task automatic model(input int mode, input bit inv);
    int N;
    N = (mode >= 2) ? 8 : ((mode == 1) ? 4 : 2);
    for (int k = 0; k < 8; k++) begin
      int g, kk;
      g = k / N;
      kk = k % N;
      er[k] = 0.0;
      ei[k] = 0.0;
      for (int m = 0; m < N; m++) begin
        real ang, c, s;
        ang = (inv ? 1.0 : -1.0) * 2.0 * PI * real'(m * kk) / real'(N);
        c = $cos(ang);
        s = $sin(ang);
        er[k] = er[k] + real'(xr[g*N+m]) * c - real'(xi[g*N+m]) * s;
        ei[k] = ei[k] + real'(xr[g*N+m]) * s + real'(xi[g*N+m]) * c;
      end
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input real tol);
    for (int k = 0; k < 8; k++) begin
      real dr, di;
      dr = real'(out_re(k)) - er[k];
      di = real'(out_im(k)) - ei[k];
      n_chk++;
      if (dr > tol || dr < -tol || di > tol || di < -tol) begin
        n_bad++;
        $display("FAIL %s lane %0d: actual=(%0d,%0d) expected=(%0.2f,%0.2f)",
                 tag, k, out_re(k), out_im(k), er[k], ei[k]);
      end
    end
  endtask

  task automatic beat(input int mode, input bit inv);
    @(negedge clk);
    in_data  = pack_in();
    in_mode  = 2'(mode);
    in_inv   = inv;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R2 out_valid after accept", out_valid, 1'b1);
  endtask

  task automatic t_reset();
    chk_bit("R1 out_valid after reset", out_valid, 1'b0);
    chk_bit("R1 in_ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_radix2();
    load_pat(1);
    xr[2] = 2047; xi[2] = -2048; xr[3] = -2048; xi[3] = 2047;
    beat(0, 1'b0);
    model(0, 1'b0);
    cmp("R4 radix-2", 0.01);
  endtask

  task automatic t_radix4();
    load_pat(2);
    beat(1, 1'b0);
    model(1, 1'b0);
    cmp("R5 radix-4", 0.01);
  endtask

  task automatic t_radix8();
    load_pat(3);
    beat(2, 1'b0);
    model(2, 1'b0);
    cmp("R6 radix-8", 3.0);
    load_pat(4);
    beat(3, 1'b0);
    model(2, 1'b0);
    cmp("R6 radix-8 code 3", 3.0);
  endtask

  task automatic t_impulse();
    clear_pat();
    xr[0] = -1234; xi[0] = 567;
    beat(3, 1'b0);
    model(2, 1'b0);
    cmp("R6 lane-0 impulse", 0.01);
  endtask

  task automatic t_rot();
    clear_pat();
    xr[1] = 1000;
    beat(2, 1'b0);
    er = '{1000.0, 707.0, 0.0, -707.0, -1000.0, -707.0, 0.0, 707.0};
    ei = '{0.0, -707.0, -1000.0, -707.0, 0.0, 707.0, 1000.0, 707.0};
    cmp("R7 eighth-root rounding", 0.01);
    beat(2, 1'b1);
    for (int k = 0; k < 8; k++) ei[k] = -ei[k];
    cmp("R8 inverse radix-8 rotation", 0.01);
  endtask

  task automatic t_inv4();
    load_pat(5);
    beat(1, 1'b1);
    model(1, 1'b1);
    cmp("R8 inverse radix-4", 0.01);
    load_pat(6);
    beat(0, 1'b1);
    model(0, 1'b1);
    cmp("R8 inverse radix-2", 0.01);
  endtask

  task automatic t_full();
    for (int n = 0; n < 8; n++) begin
      xr[n] = 2047;
      xi[n] = -2048;
    end
    beat(2, 1'b0);
    model(2, 1'b0);
    cmp("R10 full-scale radix-8", 0.01);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    load_pat(7);
    in_data = pack_in(); in_mode = 2'd0; in_inv = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_pat(8);
    in_data = pack_in(); in_mode = 2'd2; in_inv = 1'b0; in_valid = 1'b1;
    chk_bit("R2 in_ready while reading", in_ready, 1'b1);
    chk_bit("R9 first beat valid", out_valid, 1'b1);
    load_pat(7);
    model(0, 1'b0);
    cmp("R9 back-to-back radix-2", 0.01);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R9 second beat valid", out_valid, 1'b1);
    load_pat(8);
    model(2, 1'b0);
    cmp("R9 back-to-back radix-8", 3.0);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R2 drain after read", out_valid, 1'b0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    load_pat(9);
    in_data = pack_in(); in_mode = 2'd1; in_inv = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_pat(10);
    in_data = pack_in(); in_mode = 2'd0; in_inv = 1'b1; in_valid = 1'b1;
    chk_bit("R3 in_ready low when full", in_ready, 1'b0);
    load_pat(9);
    model(1, 1'b0);
    cmp("R3 first stalled result", 0.01);
    @(posedge clk);
    @(negedge clk);
    chk_bit("R3 valid held", out_valid, 1'b1);
    chk_bit("R3 in_ready still low", in_ready, 1'b0);
    cmp("R3 held result unchanged", 0.01);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R3 second accepted on release", out_valid, 1'b1);
    load_pat(10);
    model(0, 1'b1);
    cmp("R3 result after release", 0.01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_bit("R1 out_valid in reset", out_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_radix2();
    t_radix4();
    t_radix8();
    t_impulse();
    t_rot();
    t_inv4();
    t_full();
    t_b2b();
    t_stall();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule